// File: doc/BRIEF.md
# I2C Target Engine with Per-Byte Clock Stretching

This block is a 7-bit-address I2C target (slave) for a system-side processor. It watches SCL and SDA through synchronisers and detects START and STOP conditions. After a START it compares the first byte against a programmable own address. On a match it sends ACK. The last bit of that first byte sets the direction: the engine either receives bytes from the controller or sends bytes to it.

Each byte is passed through one 8-bit data register, and the engine holds SCL low until software services it. In the receive direction it stretches after each incoming byte until software reads the byte, and then it acknowledges it. In the send direction it stretches until software writes the next byte. A first-byte flag tells software whether a received byte is the first one after the address. Three events (data, START, STOP) are latched in a raw register, gated by a mask, cleared by writing ones, and combined onto a single interrupt line.

The bus pins are open-drain. Each pin has an input and an active-high "pull low" output enable.

Top module: `i2c_target_core`

## Requirements
- R1: After reset both pull-low outputs are 0, and the status (address 2), raw event (address 5), masked event (address 6) and data (address 3) registers read 0, with `irq` low.
- R2: The engine pulls SDA low in the ninth clock after a START only when bits 7:1 of the first byte, sent MSB first, equal the own address held in bits 6:0 of address 0. After a mismatch it drives nothing until the next START.
- R3: With first-byte bit 0 = 0 (controller writes), each received byte is latched into the data register and status bit 0 (receive request) sets. SCL is held low until address 3 is read, and the engine then ACKs the byte.
- R4: Status bit 2 (first byte) is set together with the receive request only for the first data byte after the address match, and it clears when address 3 is read.
- R5: With first-byte bit 0 = 1 (controller reads), status bit 1 (transmit request) sets and SCL is held low until address 3 is written. The written byte is then shifted out MSB first.
- R6: After a sent byte, an ACK from the controller raises the transmit request and the stretch again. A NACK leaves SCL and SDA released with no request until the next START.
- R7: Raw event bit 0 sets when either request rises, bit 1 sets on a START, and bit 2 sets on a STOP. Writing 1 to a bit of address 7 clears it, and a new event in the same cycle wins over the clear.
- R8: Address 6 reads raw AND mask (mask at address 4, same bit order), and `irq` is the OR of those bits.
- R9: With bit 0 of address 1 (device active) at 0, the engine sends no ACK, holds no line, and latches no event.
- R10: Writing address 3 and then reading it returns the written value while no byte is received in between.
- R11: A repeated START re-decodes the address and direction, and the next received byte reports first byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading address 3 services a receive) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | OR of masked events |
| scl_in | input | 1 | SCL line level |
| scl_oe_low | output | 1 | Pull SCL low |
| sda_in | input | 1 | SDA line level |
| sda_oe_low | output | 1 | Pull SDA low |

## Verification
The hardest states to reach are the two stretch points: the bus is frozen there, and software alone must release it. The bench models the controller as a wired-AND driver that releases SCL and then waits for the line to actually rise. It checks the held line and the status flags while the engine owns SCL, then services the data register and resumes clocking. A repeated START after an acknowledged byte and a NACK on the last sent byte drive the engine out of the middle of a transfer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int NUM_EV = 3;

  localparam logic [2:0] REG_OWN    = 3'd0;
  localparam logic [2:0] REG_CTRL   = 3'd1;
  localparam logic [2:0] REG_STAT   = 3'd2;
  localparam logic [2:0] REG_DATA   = 3'd3;
  localparam logic [2:0] REG_MASK   = 3'd4;
  localparam logic [2:0] REG_RAW    = 3'd5;
  localparam logic [2:0] REG_MASKED = 3'd6;
  localparam logic [2:0] REG_CLR    = 3'd7;

  localparam int EV_DATA  = 0;
  localparam int EV_START = 1;
  localparam int EV_STOP  = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX_BYTE, ST_RX_WAIT, ST_RX_ACK,
    ST_TX_WAIT, ST_TX_BYTE, ST_TX_ACK, ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_pipe, sda_pipe;
  logic scl_now, scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[DEPTH-2:0], scl_pin};
      sda_pipe <= {sda_pipe[DEPTH-2:0], sda_pin};
    end
  end

  assign scl_now  = scl_pipe[STAGES-1];
  assign scl_prev = scl_pipe[STAGES];
  assign sda_s    = sda_pipe[STAGES-1];
  assign sda_prev = sda_pipe[STAGES];

  assign scl_rise = scl_now & ~scl_prev;
  assign scl_fall = ~scl_now & scl_prev;
  // SCL must be high in both samples so an SDA change made together with an SCL release is not taken as a condition
  assign start_ev = scl_now & scl_prev & sda_prev & ~sda_s;
  assign stop_ev  = scl_now & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic              scl_hold,
  output logic              sda_low,
  output logic              rx_req,
  output logic              tx_req,
  output logic              first_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              req_ev
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic rw_q, rw_n, nack_q, nack_n, pend_q, pend_n;
  logic hold_q, hold_n, sdal_q, sdal_n;
  logic rxr_q, rxr_n, txr_q, txr_n, fb_q, fb_n;

  always_comb begin
    state_n = state_q; cnt_n = cnt_q; sh_n = sh_q; rw_n = rw_q;
    nack_n = nack_q; pend_n = pend_q; hold_n = hold_q; sdal_n = sdal_q;
    rxr_n = rxr_q; txr_n = txr_q; fb_n = fb_q;
    byte_done = 1'b0; req_ev = 1'b0;
    if (!active || start_ev || stop_ev) begin
      state_n = (active && start_ev) ? ST_ADDR : ST_IDLE;
      cnt_n = '0; hold_n = 1'b0; sdal_n = 1'b0;
      rxr_n = 1'b0; txr_n = 1'b0; fb_n = 1'b0; pend_n = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (sh_q[BYTE_W-1:1] == own_addr) begin
              sdal_n  = 1'b1;
              rw_n    = sh_q[0];
              state_n = ST_ADDR_ACK;
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            sdal_n = 1'b0;
            cnt_n  = '0;
            if (rw_q) begin
              hold_n = 1'b1; txr_n = 1'b1; req_ev = 1'b1;
              state_n = ST_TX_WAIT;
            end else begin
              pend_n  = 1'b1;
              state_n = ST_RX_BYTE;
            end
          end
        end
        ST_RX_BYTE: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            hold_n = 1'b1; rxr_n = 1'b1; fb_n = pend_q; pend_n = 1'b0;
            byte_done = 1'b1; req_ev = 1'b1;
            state_n = ST_RX_WAIT;
          end
        end
        ST_RX_WAIT: begin
          if (host_rd) begin
            rxr_n = 1'b0; fb_n = 1'b0; sdal_n = 1'b1; hold_n = 1'b0;
            state_n = ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sdal_n = 1'b0; cnt_n = '0;
            state_n = ST_RX_BYTE;
          end
        end
        ST_TX_WAIT: begin
          if (host_wr) begin
            sh_n = host_wdata; sdal_n = ~host_wdata[BYTE_W-1];
            hold_n = 1'b0; txr_n = 1'b0; cnt_n = '0;
            state_n = ST_TX_BYTE;
          end
        end
        ST_TX_BYTE: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              sdal_n  = 1'b0;
              state_n = ST_TX_ACK;
            end else begin
              sh_n   = {sh_q[BYTE_W-2:0], 1'b0};
              sdal_n = ~sh_q[BYTE_W-2];
              cnt_n  = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            nack_n = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_n = ST_SKIP;
            end else begin
              hold_n = 1'b1; txr_n = 1'b1; req_ev = 1'b1;
              state_n = ST_TX_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; rw_q <= 1'b0;
      nack_q <= 1'b0; pend_q <= 1'b0; hold_q <= 1'b0; sdal_q <= 1'b0;
      rxr_q <= 1'b0; txr_q <= 1'b0; fb_q <= 1'b0;
    end else begin
      state_q <= state_n; cnt_q <= cnt_n; sh_q <= sh_n; rw_q <= rw_n;
      nack_q <= nack_n; pend_q <= pend_n; hold_q <= hold_n; sdal_q <= sdal_n;
      rxr_q <= rxr_n; txr_q <= txr_n; fb_q <= fb_n;
    end
  end

  assign scl_hold   = hold_q;
  assign sda_low    = sdal_q;
  assign rx_req     = rxr_q;
  assign tx_req     = txr_q;
  assign first_byte = fb_q;
  assign rx_byte    = sh_q;
endmodule

// File: rtl/i2c_tgt_irq.sv
module i2c_tgt_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] mask,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_ev
    logic bit_n;
    always_comb begin
      bit_n = raw[i];
      if (set_vec[i])      bit_n = 1'b1;
      else if (clr_vec[i]) bit_n = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw[i] <= 1'b0;
      else        raw[i] <= bit_n;
    end
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq,
  input  logic        scl_in,
  output logic        scl_oe_low,
  input  logic        sda_in,
  output logic        sda_oe_low
);
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  logic [ADDR_W-1:0] own_q;
  logic              ctrl_active_q;
  logic [BYTE_W-1:0] data_q, data_n;
  logic [NUM_EV-1:0] mask_q, raw_q, masked, set_vec, clr_vec;
  logic host_wr, host_rd;
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic scl_hold, sda_low, rx_req, tx_req, first_byte, byte_done, req_ev;
  logic [BYTE_W-1:0] rx_byte;
  logic own_en, ctrl_en, mask_en;

  assign host_wr = bus_wr && bus_addr == REG_DATA;
  assign host_rd = bus_rd && bus_addr == REG_DATA;
  assign own_en  = bus_wr && bus_addr == REG_OWN;
  assign ctrl_en = bus_wr && bus_addr == REG_CTRL;
  assign mask_en = bus_wr && bus_addr == REG_MASK;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_pin(scl_in), .sda_pin(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_tgt_engine u_eng (
    .clk(clk), .rst_n(rst_sync_n), .active(ctrl_active_q), .own_addr(own_q),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(bus_wdata),
    .scl_hold(scl_hold), .sda_low(sda_low), .rx_req(rx_req), .tx_req(tx_req),
    .first_byte(first_byte), .byte_done(byte_done), .rx_byte(rx_byte),
    .req_ev(req_ev)
  );

  always_comb begin
    set_vec = '0;
    set_vec[EV_DATA]  = req_ev;
    set_vec[EV_START] = start_ev & ctrl_active_q;
    set_vec[EV_STOP]  = stop_ev & ctrl_active_q;
    clr_vec = (bus_wr && bus_addr == REG_CLR) ? bus_wdata[NUM_EV-1:0] : '0;
  end

  i2c_tgt_irq #(.N(NUM_EV)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask(mask_q), .raw(raw_q), .masked(masked), .irq(irq)
  );

  always_comb begin
    data_n = data_q;
    if (host_wr)        data_n = bus_wdata;
    else if (byte_done) data_n = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      own_q <= '0; ctrl_active_q <= 1'b0; mask_q <= '0; data_q <= '0;
    end else begin
      if (own_en)  own_q <= bus_wdata[ADDR_W-1:0];
      if (ctrl_en) ctrl_active_q <= bus_wdata[0];
      if (mask_en) mask_q <= bus_wdata[NUM_EV-1:0];
      data_q <= data_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_OWN:    bus_rdata[ADDR_W-1:0] = own_q;
      REG_CTRL:   bus_rdata[0] = ctrl_active_q;
      REG_STAT:   bus_rdata[2:0] = {first_byte, tx_req, rx_req};
      REG_DATA:   bus_rdata = data_q;
      REG_MASK:   bus_rdata[NUM_EV-1:0] = mask_q;
      REG_RAW:    bus_rdata[NUM_EV-1:0] = raw_q;
      REG_MASKED: bus_rdata[NUM_EV-1:0] = masked;
      default:    bus_rdata = '0;
    endcase
  end

  assign scl_oe_low = scl_hold;
  assign sda_oe_low = sda_low;
endmodule

// File: rtl/i2c_target_core_chk.sv
module i2c_target_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_active,
  input logic       scl_oe_low,
  input logic       sda_oe_low,
  input logic       rx_req,
  input logic       tx_req,
  input logic       first_byte,
  input logic       host_rd,
  input logic [2:0] raw,
  input logic [2:0] mask,
  input logic [2:0] set_vec,
  input logic [2:0] clr_vec,
  input logic       irq
);
  p_off_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_active |=> (!scl_oe_low && !sda_oe_low));
  p_one_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_req, tx_req}));
  p_first_needs_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    first_byte |-> rx_req);
  p_stretch_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe_low |-> (rx_req || tx_req));
  p_read_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && rx_req && ctrl_active) |=> (!rx_req && !scl_oe_low));
  p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[0] && !set_vec[0]) |=> !raw[0]);
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw & mask) != 3'b000));
endmodule

bind i2c_target_core i2c_target_core_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ctrl_active(ctrl_active_q),
  .scl_oe_low(scl_oe_low), .sda_oe_low(sda_oe_low), .rx_req(rx_req),
  .tx_req(tx_req), .first_byte(first_byte), .host_rd(host_rd), .raw(raw_q),
  .mask(mask_q), .set_vec(set_vec), .clr_vec(clr_vec), .irq(irq)
);

// File: tb/i2c_target_core_bench.sv
`timescale 1ns/1ps
module i2c_target_core_bench;
  localparam int H = 6;
  localparam int WD = 190000;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq, scl_oe_low, sda_oe_low;
  logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
  wire scl_line = ~(tb_scl_low | scl_oe_low);
  wire sda_line = ~(tb_sda_low | sda_oe_low);
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  i2c_target_core u_i2c_target_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_in(scl_line), .scl_oe_low(scl_oe_low), .sda_in(sda_line),
    .sda_oe_low(sda_oe_low)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_scl_high();
    for (int i = 0; i < 2000 && !scl_line; i++) @(negedge clk);
    if (!scl_line) begin
      n_tests++; n_fail++;
      $display("FAIL R3: SCL stuck low, actual 0 expected 1");
    end
  endtask

  task automatic clock_bit(input logic drive_low, output logic sample);
    tb_sda_low = drive_low; idle(H);
    tb_scl_low = 1'b0; wait_scl_high(); idle(H);
    sample = sda_line;
    tb_scl_low = 1'b1; idle(H);
  endtask

  task automatic i2c_start();
    tb_sda_low = 1'b0; idle(H);
    tb_scl_low = 1'b0; wait_scl_high(); idle(H);
    tb_sda_low = 1'b1; idle(H);
    tb_scl_low = 1'b1; idle(H);
  endtask

  task automatic i2c_stop();
    tb_sda_low = 1'b1; idle(H);
    tb_scl_low = 1'b0; wait_scl_high(); idle(H);
    tb_sda_low = 1'b0; idle(2 * H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(~b[i], s);
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 29 + i * 83 + 5) & 8'hFF);
  endfunction

  // controller writes n bytes after a write-direction address; expects first-byte on byte 0
  task automatic write_bytes(input int n, input int seed);
    logic [7:0] d; logic s;
    for (int i = 0; i < n; i++) begin
      send_byte(pat(seed, i));
      tb_sda_low = 1'b0; tb_scl_low = 1'b0; idle(20);
      chk("R3 stretch on received byte", scl_line, 0);
      bus_read(3'd2, d);
      chk("R3/R4 status rx_req and first", d, (i == 0) ? 5 : 1);
      bus_read(3'd5, d);
      chk("R7 data event raw", d[0], 1);
      bus_read(3'd3, d);
      chk("R3 received byte value", d, pat(seed, i));
      bus_read(3'd2, d);
      chk("R4 flags cleared by read", d, 0);
      bus_write(3'd7, 8'h01);
      clock_bit(1'b0, s);
      chk("R3 ack after read", s, 0);
    end
  endtask

  // controller reads n bytes; NACK on the last one
  task automatic read_bytes(input int n, input int seed);
    logic [7:0] d, got; logic s;
    for (int i = 0; i < n; i++) begin
      tb_sda_low = 1'b0; tb_scl_low = 1'b0; idle(20);
      chk((i == 0) ? "R5 stretch for transmit" : "R6 stretch after ack", scl_line, 0);
      bus_read(3'd2, d);
      chk("R5 status tx_req", d, 2);
      bus_write(3'd3, pat(seed, i));
      for (int k = 7; k >= 0; k--) begin
        clock_bit(1'b0, s);
        got[k] = s;
      end
      chk("R5 sent byte MSB first", got, pat(seed, i));
      clock_bit(i != n - 1, s);
    end
    tb_sda_low = 1'b0; tb_scl_low = 1'b0; idle(20);
    chk("R6 no stretch after nack", scl_line, 1);
    bus_read(3'd2, d);
    chk("R6 no request after nack", d, 0);
    clock_bit(1'b0, s);
    chk("R6 SDA released after nack", s, 1);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d; logic s;
    idle(5); rst_n = 1'b1; idle(5);
    // R1 reset state
    chk("R1 SCL released", scl_line, 1);
    chk("R1 SDA released", sda_line, 1);
    bus_read(3'd2, d); chk("R1 status", d, 0);
    bus_read(3'd5, d); chk("R1 raw", d, 0);
    bus_read(3'd6, d); chk("R1 masked", d, 0);
    bus_read(3'd3, d); chk("R1 data", d, 0);
    chk("R1 irq", irq, 0);
    // R10 persistence
    bus_write(3'd3, 8'hA5); idle(3);
    bus_read(3'd3, d); chk("R10 data readback", d, 8'hA5);
    bus_read(3'd3, d); chk("R10 data persists", d, 8'hA5);

    bus_write(3'd0, {1'b0, OWN});
    bus_write(3'd1, 8'h01);
    bus_write(3'd4, 8'h07);
    // R2 address sweep over every 7-bit address
    for (int a = 0; a < 128; a++) begin
      i2c_start();
      send_byte({7'(a), 1'b0});
      clock_bit(1'b0, s);
      chk("R2 ack only on own address", ~s & 1'b1, (a == OWN) ? 1 : 0);
      i2c_stop();
    end
    bus_read(3'd5, d); chk("R7 start and stop latched, no data", d, 6);
    chk("R8 irq with mask", irq, 1);
    bus_write(3'd4, 8'h00);
    bus_read(3'd6, d); chk("R8 masked zero", d, 0);
    chk("R8 irq off with mask 0", irq, 0);
    bus_write(3'd4, 8'h02);
    bus_read(3'd6, d); chk("R8 masked start only", d, 2);
    bus_write(3'd4, 8'h07);
    bus_write(3'd7, 8'h07);
    bus_read(3'd5, d); chk("R7 write-1 clear", d, 0);

    // R3 R4 controller writes
    i2c_start(); send_byte({OWN, 1'b0}); clock_bit(1'b0, s);
    chk("R2 ack write address", s, 0);
    write_bytes(16, 1);
    i2c_stop();
    bus_read(3'd5, d); chk("R7 stop after write", d[2], 1);
    bus_write(3'd7, 8'h07);

    // R5 R6 controller reads
    i2c_start(); send_byte({OWN, 1'b1}); clock_bit(1'b0, s);
    chk("R2 ack read address", s, 0);
    read_bytes(16, 7);
    i2c_stop();
    bus_write(3'd7, 8'h07);

    // R11 repeated start: write one byte, then re-address for read, then write again
    i2c_start(); send_byte({OWN, 1'b0}); clock_bit(1'b0, s);
    write_bytes(1, 3);
    i2c_start(); send_byte({OWN, 1'b1}); clock_bit(1'b0, s);
    chk("R11 ack after repeated start", s, 0);
    read_bytes(2, 4);
    i2c_start(); send_byte({OWN, 1'b0}); clock_bit(1'b0, s);
    chk("R11 ack on second repeated start", s, 0);
    write_bytes(2, 9);
    i2c_stop();
    bus_write(3'd7, 8'h07);

    // R9 disabled
    bus_write(3'd1, 8'h00);
    i2c_start(); send_byte({OWN, 1'b0}); clock_bit(1'b0, s);
    chk("R9 no ack when inactive", s, 1);
    send_byte(8'h55);
    tb_scl_low = 1'b0; idle(20);
    chk("R9 no stretch when inactive", scl_line, 1);
    i2c_stop();
    bus_read(3'd5, d); chk("R9 no events when inactive", d, 0);
    bus_read(3'd2, d); chk("R9 no requests when inactive", d, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule